// File: doc/BRIEF.md
# USB Device Event Flag and Interrupt Register Bank

This block collects the single-cycle event strobes that a low-speed USB device engine produces and keeps each one in a sticky flag. The events are end of packet, bus reset, resume, transmit done on endpoints 0, 1 and 2, and receive done on endpoint 0. The CPU reaches the bank over a byte-wide register port. Through that port it reads the flags, clears chosen flags by writing ones to a dedicated clear register, and sets the interrupt enables of the three endpoint-done flags.

One registered interrupt request line is the OR of every flag qualified by its enable. The four flags that have no software enable are qualified by a fixed parameter instead, so that each of them either raises an interrupt or is only polled.

Top module: `usb_evt_flag_bank`

## Requirements
- R1: After reset, the status register, the enable register and the interrupt request output are all 0.
- R2: The status byte holds the end-of-packet flag at bit 7, bus reset at bit 6, endpoint 2 transmit at bit 5, endpoint 1 transmit at bit 3, resume at bit 2, endpoint 0 transmit at bit 1 and endpoint 0 receive at bit 0. Bit 4 always reads 0.
- R3: A one-cycle event pulse sets its flag at the next clock edge, and the flag stays set until software clears it.
- R4: The register offsets are: status at 0, clear at 1, enable at 2. A write to offset 0 or offset 3 changes no flag and no enable bit, and offset 3 reads 0.
- R5: Writing 1 to a bit of the clear register (offset 1, same bit layout as status) clears that flag. Writing 0 leaves the flag unchanged. The clear register always reads 0.
- R6: When an event pulse and a clear write hit the same flag in the same cycle, the flag is set afterwards.
- R7: The enable register (offset 2) holds read/write enables for endpoint 0 receive (bit 0), endpoint 0 transmit (bit 1) and endpoint 1 transmit (bit 3). Its other bits read 0. An endpoint flag contributes to the interrupt only while its enable is 1.
- R8: The end-of-packet, bus reset, endpoint 2 transmit and resume flags contribute to the interrupt according to the FIXED_EN parameter. The default value enables all four.
- R9: The interrupt request output is registered. It rises one clock after an enabled flag becomes set, and it falls one clock after the last enabled pending flag is cleared or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register offset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| evtPktEnd | input | 1 | End-of-packet event pulse |
| evtBusRst | input | 1 | Bus reset event pulse |
| evtResume | input | 1 | Resume event pulse |
| evtTx0Done | input | 1 | Endpoint 0 transmit done pulse |
| evtTx1Done | input | 1 | Endpoint 1 transmit done pulse |
| evtTx2Done | input | 1 | Endpoint 2 transmit done pulse |
| evtRx0Done | input | 1 | Endpoint 0 receive done pulse |
| irqReq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a clear write and a new event for the same flag arriving in one cycle. The bench drives the clear write and the event pulses inside a single bus cycle and checks that the flag that was hit survives. It also checks that flags which saw only the clear are gone.

The one-cycle lag of the interrupt line is checked by reading status in the cycle right after a pulse, and again in the cycle after that. A write of all ones to the read-only status offset is followed by reads of both status and enable, to show that nothing moved.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;

  localparam int BYTE_W = 8;

  // Status and clear bit positions (fixed layout that software decodes)
  localparam int POS_RX0 = 0;
  localparam int POS_TX0 = 1;
  localparam int POS_RSM = 2;
  localparam int POS_TX1 = 3;
  localparam int POS_TX2 = 5;
  localparam int POS_BRST = 6;
  localparam int POS_EOP = 7;

  localparam logic [BYTE_W-1:0] IMPL_MASK = 8'hEF;
  localparam logic [BYTE_W-1:0] ENAB_MASK = 8'h0B;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_STATUS = 2'd1,
    RD_ENABLE = 2'd2
  } rdSel_t;

  typedef struct packed {
    logic              clrWr;
    logic              enWr;
    logic [BYTE_W-1:0] wrData;
    rdSel_t            rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/usb_evt_ctrl.sv
module usb_evt_ctrl
  import usb_evt_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int OFS_STATUS = 0,
  parameter int OFS_CLEAR = 1,
  parameter int OFS_ENABLE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BYTE_W-1:0] busWrData,
  output ctrlStrobe_t       strobe
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);

  logic hitStatus, hitClear, hitEnable;

  always_comb begin
    hitStatus = (busAddr == A_STATUS);
    hitClear = (busAddr == A_CLEAR);
    hitEnable = (busAddr == A_ENABLE);
  end

  always_comb begin
    strobe = '0;
    strobe.wrData = busWrData;
    strobe.clrWr = busWrEn && hitClear;
    strobe.enWr = busWrEn && hitEnable;
    if (hitStatus) strobe.rdSel = RD_STATUS;
    else if (hitEnable) strobe.rdSel = RD_ENABLE;
    else strobe.rdSel = RD_ZERO;
  end

  // R4
  status_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && hitStatus) |-> !(strobe.clrWr || strobe.enWr));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clrWr, strobe.enWr}));

endmodule

// File: rtl/usb_evt_dpath.sv
module usb_evt_dpath
  import usb_evt_pkg::*;
#(
  parameter logic [3:0] FIXED_EN = 4'hF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [BYTE_W-1:0] evtVec,
  output logic [BYTE_W-1:0] rdData,
  output logic              irqReq
);

  logic [BYTE_W-1:0] flagQ;
  logic [BYTE_W-1:0] enQ;
  logic [BYTE_W-1:0] clrMask;
  logic [BYTE_W-1:0] fixedVec;
  logic [BYTE_W-1:0] effEn;
  logic              pending;
  logic              irqQ;

  always_comb begin
    clrMask = strobe.clrWr ? strobe.wrData : '0;
    fixedVec = '0;
    fixedVec[POS_EOP] = FIXED_EN[3];
    fixedVec[POS_BRST] = FIXED_EN[2];
    fixedVec[POS_TX2] = FIXED_EN[1];
    fixedVec[POS_RSM] = FIXED_EN[0];
    effEn = (enQ & ENAB_MASK) | fixedVec;
    pending = |(flagQ & effEn);
  end

  for (genvar i = 0; i < BYTE_W; i++) begin : gFlag
    if (IMPL_MASK[i]) begin : gImpl
      logic cellQ;
      always_ff @(posedge clk) begin
        if (!rstN) cellQ <= 1'b0;
        else cellQ <= (cellQ && !clrMask[i]) || evtVec[i];
      end
      assign flagQ[i] = cellQ;

      // R3
      flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (cellQ && !clrMask[i]) |=> cellQ);
      // R6
      evt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
        evtVec[i] |=> cellQ);
      // R5
      flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        (clrMask[i] && !evtVec[i]) |=> !cellQ);
    end else begin : gNone
      assign flagQ[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) enQ <= '0;
    else if (strobe.enWr) enQ <= strobe.wrData & ENAB_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else irqQ <= pending;
  end

  assign irqReq = irqQ;

  always_comb begin
    case (strobe.rdSel)
      RD_STATUS: rdData = flagQ;
      RD_ENABLE: rdData = enQ & ENAB_MASK;
      default:   rdData = '0;
    endcase
  end

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending |=> irqReq);
  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pending |=> !irqReq);

endmodule

// File: rtl/usb_evt_flag_bank.sv
module usb_evt_flag_bank
  import usb_evt_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [3:0] FIXED_EN = 4'hF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              evtPktEnd,
  input  logic              evtBusRst,
  input  logic              evtResume,
  input  logic              evtTx0Done,
  input  logic              evtTx1Done,
  input  logic              evtTx2Done,
  input  logic              evtRx0Done,
  output logic              irqReq
);

  ctrlStrobe_t       strobe;
  logic [BYTE_W-1:0] evtVec;

  always_comb begin
    evtVec = '0;
    evtVec[POS_EOP] = evtPktEnd;
    evtVec[POS_BRST] = evtBusRst;
    evtVec[POS_TX2] = evtTx2Done;
    evtVec[POS_TX1] = evtTx1Done;
    evtVec[POS_RSM] = evtResume;
    evtVec[POS_TX0] = evtTx0Done;
    evtVec[POS_RX0] = evtRx0Done;
  end

  usb_evt_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busWrData(busWrData),
    .strobe(strobe)
  );

  usb_evt_dpath #(
    .FIXED_EN(FIXED_EN)
  ) u_dpath (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .evtVec(evtVec),
    .rdData(busRdData),
    .irqReq(irqReq)
  );

endmodule

// File: tb/usb_evt_flag_bank_bench.sv
module usb_evt_flag_bank_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       evtPktEnd = 1'b0, evtBusRst = 1'b0, evtResume = 1'b0;
  logic       evtTx0Done = 1'b0, evtTx1Done = 1'b0, evtTx2Done = 1'b0, evtRx0Done = 1'b0;
  logic       irqReq;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0] addr;
    logic [7:0] expData;
    logic       expIrq;
    string      tag;
  } item_t;

  item_t sbq[$];

  always #4 clk = ~clk;

  usb_evt_flag_bank u_usb_evt_flag_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .evtPktEnd(evtPktEnd), .evtBusRst(evtBusRst), .evtResume(evtResume),
    .evtTx0Done(evtTx0Done), .evtTx1Done(evtTx1Done), .evtTx2Done(evtTx2Done),
    .evtRx0Done(evtRx0Done), .irqReq(irqReq)
  );

  // Event vector in status layout: 7 eop, 6 bus reset, 5 tx2, 3 tx1, 2 resume, 1 tx0, 0 rx0
  task automatic setEvt(input logic [7:0] v);
    evtPktEnd = v[7]; evtBusRst = v[6]; evtTx2Done = v[5];
    evtTx1Done = v[3]; evtResume = v[2]; evtTx0Done = v[1]; evtRx0Done = v[0];
  endtask

  task automatic endCycle();
    @(posedge clk); #1;
    busWrEn = 1'b0;
    setEvt(8'h00);
  endtask

  task automatic idle();
    endCycle();
  endtask

  task automatic pulse(input logic [7:0] v);
    setEvt(v);
    endCycle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    endCycle();
  endtask

  task automatic wrPulse(input logic [1:0] a, input logic [7:0] d, input logic [7:0] v);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    setEvt(v);
    endCycle();
  endtask

  task automatic chk(input logic [1:0] a, input logic [7:0] d, input logic q, input string tag);
    item_t it;
    busAddr = a;
    it.addr = a; it.expData = d; it.expIrq = q; it.tag = tag;
    sbq.push_back(it);
    endCycle();
  endtask

  // Monitor: compares one scoreboard item per cycle, away from the clock edge
  always @(negedge clk) begin
    item_t it;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      testsRun++;
      if (busRdData !== it.expData || irqReq !== it.expIrq) begin
        testsFailed++;
        $display("FAIL %s addr=%0d data=%02h irq=%0b expected data=%02h irq=%0b",
                 it.tag, it.addr, busRdData, irqReq, it.expData, it.expIrq);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    chk(2'd0, 8'h00, 1'b0, "R1 status");
    chk(2'd2, 8'h00, 1'b0, "R1 enable");
    chk(2'd1, 8'h00, 1'b0, "R5 clear reads zero");
    // R3 sticky flag, R7 masked by enable 0
    pulse(8'h01); idle();
    chk(2'd0, 8'h01, 1'b0, "R3 rx0 flag sticky, R7 masked");
    wr(2'd2, 8'h01); idle();
    chk(2'd2, 8'h01, 1'b1, "R7 rx0 enabled");
    // R4 status is read-only
    wr(2'd0, 8'hFF); idle();
    chk(2'd0, 8'h01, 1'b1, "R4 status write ignored");
    chk(2'd2, 8'h01, 1'b1, "R4 enable untouched");
    // R5 zero bits of clear have no effect, then one clears
    wr(2'd1, 8'hFE); idle();
    chk(2'd0, 8'h01, 1'b1, "R5 zero write no effect");
    wr(2'd1, 8'h01); idle();
    chk(2'd0, 8'h00, 1'b0, "R5 flag cleared");
    // R9 one-cycle interrupt latency, rise and fall
    pulse(8'h01);
    chk(2'd0, 8'h01, 1'b0, "R9 irq not yet high");
    chk(2'd0, 8'h01, 1'b1, "R9 irq high");
    wr(2'd1, 8'h01);
    chk(2'd0, 8'h00, 1'b1, "R9 irq still high");
    chk(2'd0, 8'h00, 1'b0, "R9 irq low");
    // R8 fixed-enable flags, R2 positions
    pulse(8'h80); idle();
    chk(2'd0, 8'h80, 1'b1, "R8 end-of-packet bit7 irq");
    wr(2'd1, 8'h80); idle();
    pulse(8'h04); idle();
    chk(2'd0, 8'h04, 1'b1, "R8 resume bit2 irq");
    wr(2'd1, 8'h04); idle();
    pulse(8'h40); idle();
    chk(2'd0, 8'h40, 1'b1, "R2 bus reset bit6");
    wr(2'd1, 8'hFF); idle();
    chk(2'd0, 8'h00, 1'b0, "R5 clear all");
    // R2 all events, bit4 stays 0
    pulse(8'hFF); idle();
    chk(2'd0, 8'hEF, 1'b1, "R2 full layout bit4 zero");
    // R7 reserved enable bits read zero
    wr(2'd2, 8'hFF); idle();
    chk(2'd2, 8'h0B, 1'b1, "R7 enable implemented bits");
    // R6 event wins over same-cycle clear
    wrPulse(2'd1, 8'hFF, 8'h09); idle();
    chk(2'd0, 8'h09, 1'b1, "R6 event beats clear");
    // R7 masking removes the interrupt
    wr(2'd2, 8'h00); idle();
    chk(2'd0, 8'h09, 1'b0, "R7 endpoint flags masked");
    chk(2'd1, 8'h00, 1'b0, "R5 clear reads zero after writes");
    // R4 unused offset
    wr(2'd3, 8'hFF); idle();
    chk(2'd3, 8'h00, 1'b0, "R4 offset3 reads zero");
    chk(2'd2, 8'h00, 1'b0, "R4 offset3 write no effect on enable");
    wr(2'd1, 8'hFF); idle();
    wr(2'd2, 8'h02); pulse(8'h02); idle();
    chk(2'd0, 8'h02, 1'b1, "R7 tx0 enabled");
    pulse(8'h08); idle();
    chk(2'd0, 8'h0A, 1'b1, "R2 tx1 bit3");
    repeat (2) @(posedge clk);
    #1 done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule